// File: doc/BRIEF.md
# Chained DMA Descriptor Sequencer

This block runs the control side of a DMA channel. In chained mode it reads transfer descriptors from memory one word at a time. It loads the fields it needs into working registers and checks them. It then hands one transfer request to a separate data mover and waits for the mover to report completion. After that it either follows the descriptor's link word to the next descriptor or stops. In direct mode a single transfer is taken from input pins, and no memory is read.

A descriptor occupies seven consecutive 32-bit words starting on a 16-byte boundary:

| Word | Byte offset | Contents |
|------|-------------|----------|
| 0 | 0 | control; bit 31 is the direction |
| 1 | 4 | byte count |
| 2 | 8 | local-bus address |
| 3 | 12 | unused |
| 4 | 16 | remote-bus address |
| 5 | 20 | unused |
| 6 | 24 | link word |

The link word carries the address of the next descriptor in its upper bits. Its bit 0 flags the last entry of the chain. Bits 3:0 never form part of an address.

The descriptor read port and the mover request port are both valid/ready channels. A source that raises valid keeps it high, with its payload unchanged, until the cycle in which ready is also high; the transfer happens in that cycle. The sequencer keeps at most one read outstanding. It raises `rd_rsp_ready` only while it waits for that read's data. The mover signals that a transfer has finished with a single-cycle `mv_done` pulse.

Top module: `dma_chain_seq`

## Requirements
- R1: After reset, `busy`, `done`, `lerr`, `rd_req_valid`, `mv_valid` and `rd_rsp_ready` are all 0.
- R2: In chained mode each descriptor is read as seven requests, to the descriptor base plus 0, 4, 8, 12, 16, 20 and 24, in that order. Each request waits for its read data before the next one is issued. While `rd_req_ready` is low, a pending request holds its valid and its address.
- R3: Read data is taken as follows: word 0 bit 31 is the direction, word 1 is the byte count, word 2 is the local address, word 4 is the remote address and word 6 is the link word. Words 3 and 5 are ignored. The mover request is raised only after all seven words of the descriptor have been received.
- R4: With direction 1 the mover request has `mv_l2r`=1, `mv_src` equal to the local address and `mv_dst` equal to the remote address. With direction 0 it has `mv_l2r`=0, `mv_src` equal to the remote address and `mv_dst` equal to the local address. `mv_count` is count bits 23:0.
- R5: The start pointer and every link word have their bits 3:0 cleared to form the descriptor base. Link bits 3:1 therefore do not change the fetch address.
- R6: The chain ends when the `mv_done` that follows the completed descriptor has link bit 0 set. `done` is then high for exactly one cycle, the cycle after that `mv_done`, and `busy` falls in the same cycle. If link bit 0 is clear, the next descriptor is fetched.
- R7: A byte count of 0 or of 0x1000000 or more is rejected. The channel stops, `lerr` is set, no mover request is made for that descriptor and `done` is not pulsed. Transfers already completed earlier in the chain stand.
- R8: A descriptor whose local and remote addresses differ in bits 2:0 is rejected in the same way as in R7.
- R9: A `start` with `chain_mode`=0 performs one transfer from `dir_l2r`, `dir_count`, `dir_laddr` and `dir_raddr`. It issues no read request, applies the checks of R7 and R8, and pulses `done` on completion.
- R10: A mover request keeps `mv_valid`, `mv_count`, `mv_src` and `mv_dst` unchanged until `mv_ready` is sampled high. No further read or request is made until `mv_done` has been received.
- R11: `lerr` stays set until the next accepted `start`, which clears it. A `start` that arrives while `busy` is high is ignored and has no effect on the running chain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run; accepted only when the channel is idle |
| chain_mode | input | 1 | 1 = descriptor chain, 0 = direct transfer |
| first_ptr | input | 32 | Address of the first descriptor; bits 3:0 are ignored |
| dir_l2r | input | 1 | Direct mode direction (1 = local to remote) |
| dir_count | input | 32 | Direct mode byte count |
| dir_laddr | input | 32 | Direct mode local-bus address |
| dir_raddr | input | 32 | Direct mode remote-bus address |
| rd_req_valid | output | 1 | Descriptor read request valid |
| rd_req_ready | input | 1 | Memory accepts the read request |
| rd_req_addr | output | 32 | Byte address of the descriptor word |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_ready | output | 1 | Sequencer accepts the read data |
| rd_rsp_data | input | 32 | Read data word |
| mv_valid | output | 1 | Transfer request to the data mover |
| mv_ready | input | 1 | Mover accepts the request |
| mv_l2r | output | 1 | Transfer direction, 1 = local to remote |
| mv_count | output | 24 | Transfer byte count |
| mv_src | output | 32 | Source address |
| mv_dst | output | 32 | Destination address |
| mv_done | input | 1 | One-cycle pulse when the accepted transfer is complete |
| busy | output | 1 | Channel is running |
| done | output | 1 | One-cycle pulse at the normal end of a run |
| lerr | output | 1 | Sticky flag: a descriptor failed its checks |

## Verification
The assertions watch several properties on every cycle:
- payloads are held under back-pressure on both valid/ready channels;
- `done` lasts only one cycle and only follows `mv_done`;
- a mover request in chained mode comes only after seven read responses;
- every request that reaches the mover carries a nonzero count and matching low address bits;
- a rise of `lerr` never coincides with a request.

Only the directed scenarios can show the rest:
- that the exact address sequence is produced;
- that link bits 3:1 are masked and bit 0 ends the chain;
- that the direction swap is applied;
- that a bad descriptor further down a chain stops it after the earlier transfers;
- that a start made during a run is ignored.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  // number of 32-bit words per descriptor and the slot of each used field
  localparam int DESC_WORDS = 7;
  localparam int SLOT_CTRL  = 0;
  localparam int SLOT_COUNT = 1;
  localparam int SLOT_LADDR = 2;
  localparam int SLOT_RADDR = 4;
  localparam int SLOT_LINK  = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_CHECK,
    ST_ISSUE,
    ST_WAIT
  } seq_state_e;
endpackage

// File: rtl/dcs_fetch.sv
module dcs_fetch import dcs_pkg::*; #(
  parameter int W = 32,
  parameter int NW = DESC_WORDS,
  localparam int IDX_W = $clog2(NW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [W-1:0]     base,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [W-1:0]     req_addr,
  input  logic             rsp_valid,
  output logic             rsp_ready,
  output logic             word_we,
  output logic [IDX_W-1:0] word_sel,
  output logic             word_last
);
  logic             active;
  logic             waiting_rsp;
  logic [IDX_W-1:0] idx;
  logic [W-1:0]     base_q;

  assign req_valid = active && !waiting_rsp;
  assign rsp_ready = active && waiting_rsp;
  assign req_addr  = base_q + (W'(idx) << 2);
  assign word_we   = rsp_valid && rsp_ready;
  assign word_sel  = idx;
  assign word_last = word_we && (idx == IDX_W'(NW - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active      <= 1'b0;
      waiting_rsp <= 1'b0;
      idx         <= '0;
      base_q      <= '0;
    end else if (go) begin
      active      <= 1'b1;
      waiting_rsp <= 1'b0;
      idx         <= '0;
      base_q      <= base;
    end else if (req_valid && req_ready) begin
      waiting_rsp <= 1'b1;
    end else if (word_we) begin
      waiting_rsp <= 1'b0;
      if (word_last) begin
        active <= 1'b0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dcs_check.sv
module dcs_check #(
  parameter int W = 32,
  parameter int CNT_W = 24,
  parameter int LANE_BITS = 3
) (
  input  logic [W-1:0]         count,
  input  logic [LANE_BITS-1:0] lane_a,
  input  logic [LANE_BITS-1:0] lane_b,
  output logic                 ok
);
  logic count_ok;
  logic lane_ok;

  assign count_ok = (count != '0) && ((count >> CNT_W) == '0);
  assign lane_ok  = (lane_a == lane_b);
  assign ok       = count_ok && lane_ok;
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq import dcs_pkg::*; #(
  parameter int W = 32,
  parameter int CNT_W = 24,
  parameter int PTR_ALIGN = 4,
  parameter int LANE_BITS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             chain_mode,
  input  logic [W-1:0]     first_ptr,
  input  logic             dir_l2r,
  input  logic [W-1:0]     dir_count,
  input  logic [W-1:0]     dir_laddr,
  input  logic [W-1:0]     dir_raddr,
  output logic             rd_req_valid,
  input  logic             rd_req_ready,
  output logic [W-1:0]     rd_req_addr,
  input  logic             rd_rsp_valid,
  output logic             rd_rsp_ready,
  input  logic [W-1:0]     rd_rsp_data,
  output logic             mv_valid,
  input  logic             mv_ready,
  output logic             mv_l2r,
  output logic [CNT_W-1:0] mv_count,
  output logic [W-1:0]     mv_src,
  output logic [W-1:0]     mv_dst,
  input  logic             mv_done,
  output logic             busy,
  output logic             done,
  output logic             lerr
);
  localparam int IDX_W = $clog2(DESC_WORDS);
  localparam logic [W-1:0] PTR_MASK = {W{1'b1}} << PTR_ALIGN;

  seq_state_e       st;
  logic             chain_q;
  logic             w_l2r;
  logic [W-1:0]     w_count, w_laddr, w_raddr, w_link;
  logic             f_go, f_we, f_last;
  logic [IDX_W-1:0] f_sel;
  logic [W-1:0]     f_base;
  logic             desc_ok;
  logic             accept;
  logic             last_desc;

  assign accept    = start && (st == ST_IDLE);
  assign last_desc = !chain_q || w_link[0];
  assign f_go      = (accept && chain_mode) ||
                     (st == ST_WAIT && mv_done && !last_desc);
  assign f_base    = ((st == ST_IDLE) ? first_ptr : w_link) & PTR_MASK;

  dcs_fetch #(.W(W), .NW(DESC_WORDS)) u_fetch (
    .clk(clk), .rst_n(rst_n), .go(f_go), .base(f_base),
    .req_valid(rd_req_valid), .req_ready(rd_req_ready), .req_addr(rd_req_addr),
    .rsp_valid(rd_rsp_valid), .rsp_ready(rd_rsp_ready),
    .word_we(f_we), .word_sel(f_sel), .word_last(f_last)
  );

  dcs_check #(.W(W), .CNT_W(CNT_W), .LANE_BITS(LANE_BITS)) u_check (
    .count(w_count),
    .lane_a(w_laddr[LANE_BITS-1:0]),
    .lane_b(w_raddr[LANE_BITS-1:0]),
    .ok(desc_ok)
  );

  assign mv_valid = (st == ST_ISSUE);
  assign mv_l2r   = w_l2r;
  assign mv_count = w_count[CNT_W-1:0];
  assign mv_src   = w_l2r ? w_laddr : w_raddr;
  assign mv_dst   = w_l2r ? w_raddr : w_laddr;
  assign busy     = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      chain_q <= 1'b0;
      w_l2r   <= 1'b0;
      w_count <= '0;
      w_laddr <= '0;
      w_raddr <= '0;
      w_link  <= '0;
      done    <= 1'b0;
      lerr    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: if (accept) begin
          chain_q <= chain_mode;
          lerr    <= 1'b0;
          if (chain_mode) begin
            w_count <= '0;
            st      <= ST_FETCH;
          end else begin
            w_l2r   <= dir_l2r;
            w_count <= dir_count;
            w_laddr <= dir_laddr;
            w_raddr <= dir_raddr;
            st      <= ST_CHECK;
          end
        end
        ST_FETCH: begin
          if (f_we) begin
            if (f_sel == IDX_W'(SLOT_CTRL))  w_l2r   <= rd_rsp_data[W-1];
            if (f_sel == IDX_W'(SLOT_COUNT)) w_count <= rd_rsp_data;
            if (f_sel == IDX_W'(SLOT_LADDR)) w_laddr <= rd_rsp_data;
            if (f_sel == IDX_W'(SLOT_RADDR)) w_raddr <= rd_rsp_data;
            if (f_sel == IDX_W'(SLOT_LINK))  w_link  <= rd_rsp_data;
          end
          if (f_last) st <= ST_CHECK;
        end
        ST_CHECK: begin
          if (desc_ok) begin
            st <= ST_ISSUE;
          end else begin
            lerr <= 1'b1;
            st   <= ST_IDLE;
          end
        end
        ST_ISSUE: if (mv_ready) st <= ST_WAIT;
        ST_WAIT: if (mv_done) begin
          if (last_desc) begin
            done <= 1'b1;
            st   <= ST_IDLE;
          end else begin
            st <= ST_FETCH;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dcs_chk.sv
module dcs_chk #(
  parameter int W = 32,
  parameter int CNT_W = 24,
  parameter int LANE_BITS = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             chain_q,
  input logic             done,
  input logic             lerr,
  input logic             rd_req_valid,
  input logic             rd_req_ready,
  input logic [W-1:0]     rd_req_addr,
  input logic             rd_rsp_valid,
  input logic             rd_rsp_ready,
  input logic             mv_valid,
  input logic             mv_ready,
  input logic [CNT_W-1:0] mv_count,
  input logic [W-1:0]     mv_src,
  input logic [W-1:0]     mv_dst,
  input logic             mv_done
);
  logic [3:0] rsp_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_seen <= '0;
    end else if ((start && !busy) || (mv_valid && mv_ready)) begin
      rsp_seen <= '0;
    end else if (rd_rsp_valid && rd_rsp_ready && rsp_seen != 4'hF) begin
      rsp_seen <= rsp_seen + 1'b1;
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !lerr));

  // R6
  done_after_mover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(mv_done));

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

  // R10
  mv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_valid && !mv_ready) |=>
      (mv_valid && $stable(mv_count) && $stable(mv_src) && $stable(mv_dst)));

  // R3
  seven_words_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_valid && chain_q) |-> (rsp_seen == 4'd7));

  // R7
  count_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mv_valid |-> (mv_count != '0));

  // R8
  lane_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mv_valid |-> (mv_src[LANE_BITS-1:0] == mv_dst[LANE_BITS-1:0]));

  // R7
  err_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lerr) |-> (!mv_valid && !busy));
endmodule

bind dma_chain_seq dcs_chk #(.W(W), .CNT_W(CNT_W), .LANE_BITS(LANE_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .chain_q(chain_q),
  .done(done), .lerr(lerr), .rd_req_valid(rd_req_valid),
  .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
  .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready),
  .mv_valid(mv_valid), .mv_ready(mv_ready), .mv_count(mv_count),
  .mv_src(mv_src), .mv_dst(mv_dst), .mv_done(mv_done)
);

// File: tb/tb_dma_chain_seq.sv
`timescale 1ns/1ps
module tb_dma_chain_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        chain_mode = 1'b0;
  logic [31:0] first_ptr = '0;
  logic        dir_l2r = 1'b0;
  logic [31:0] dir_count = '0, dir_laddr = '0, dir_raddr = '0;
  logic        rd_req_valid, rd_rsp_ready;
  logic        rd_req_ready = 1'b1;
  logic [31:0] rd_req_addr;
  logic        rd_rsp_valid = 1'b0;
  logic [31:0] rd_rsp_data = '0;
  logic        mv_valid, mv_l2r;
  logic        mv_ready = 1'b1;
  logic        mv_done = 1'b0;
  logic [23:0] mv_count;
  logic [31:0] mv_src, mv_dst;
  logic        busy, done, lerr;

  dma_chain_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .chain_mode(chain_mode),
    .first_ptr(first_ptr), .dir_l2r(dir_l2r), .dir_count(dir_count),
    .dir_laddr(dir_laddr), .dir_raddr(dir_raddr),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data),
    .mv_valid(mv_valid), .mv_ready(mv_ready), .mv_l2r(mv_l2r),
    .mv_count(mv_count), .mv_src(mv_src), .mv_dst(mv_dst),
    .mv_done(mv_done), .busy(busy), .done(done), .lerr(lerr)
  );

  initial forever #4 clk = ~clk;

  int n_tests = 0;
  int n_fail = 0;
  logic [31:0] mem [0:63];
  logic stall_rd = 1'b0, stall_mv = 1'b0;
  int req_n = 0, rsp_cnt = 0, iss_n = 0;
  logic [31:0] req_log [0:31];
  logic        iss_dir [0:7];
  logic [23:0] iss_cnt [0:7];
  logic [31:0] iss_src [0:7], iss_dst [0:7];
  int          iss_w   [0:7];
  logic d1, d2, le;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory model: one response per accepted request, delivered one cycle later
  initial begin
    logic pend = 1'b0, clr = 1'b0;
    logic [31:0] paddr = '0;
    forever begin
      @(negedge clk);
      if (clr) begin rd_rsp_valid = 1'b0; clr = 1'b0; end
      if (pend) begin rd_rsp_valid = 1'b1; rd_rsp_data = mem[paddr[7:2]]; pend = 1'b0; end
      if (rd_rsp_valid && rd_rsp_ready) begin clr = 1'b1; rsp_cnt++; end
      rd_req_ready = stall_rd ? ~rd_req_ready : 1'b1;
      if (rd_req_valid && rd_req_ready) begin
        if (req_n < 32) req_log[req_n] = rd_req_addr;
        req_n++;
        pend = 1'b1;
        paddr = rd_req_addr;
      end
    end
  end

  // mover stub: completes three cycles after accepting a request
  initial begin
    int lat = 0;
    forever begin
      @(negedge clk);
      mv_done = 1'b0;
      if (lat > 0) begin lat--; if (lat == 0) mv_done = 1'b1; end
      mv_ready = stall_mv ? ~mv_ready : 1'b1;
      if (mv_valid && mv_ready) begin
        if (iss_n < 8) begin
          iss_dir[iss_n] = mv_l2r; iss_cnt[iss_n] = mv_count;
          iss_src[iss_n] = mv_src; iss_dst[iss_n] = mv_dst; iss_w[iss_n] = rsp_cnt;
        end
        iss_n++;
        lat = 3;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic reset_logs();
    for (int i = 0; i < 64; i++) mem[i] = 32'hDEAD_0000 | 32'(i);
    req_n = 0; rsp_cnt = 0; iss_n = 0;
  endtask

  task automatic put_desc(input int base, input logic l2r, input logic [31:0] cnt,
                          input logic [31:0] la, input logic [31:0] ra, input logic [31:0] link);
    mem[base/4 + 0] = {l2r, 31'h0000_1234};
    mem[base/4 + 1] = cnt;
    mem[base/4 + 2] = la;
    mem[base/4 + 4] = ra;
    mem[base/4 + 6] = link;
  endtask

  task automatic kick(input logic chain, input logic [31:0] ptr);
    @(negedge clk);
    start = 1'b1; chain_mode = chain; first_ptr = ptr;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end();
    int g = 0;
    while (busy && g < 3000) begin @(negedge clk); g++; end
    d1 = done; le = lerr;
    @(negedge clk);
    d2 = done;
  endtask

  task automatic t_reset();
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 lerr", 32'(lerr), 0);
    chk("R1 rd_req_valid", 32'(rd_req_valid), 0);
    chk("R1 mv_valid", 32'(mv_valid), 0);
    chk("R1 rd_rsp_ready", 32'(rd_rsp_ready), 0);
  endtask

  task automatic t_chain_two();
    reset_logs();
    put_desc(32'h40, 1'b1, 32'h100, 32'h1000_0004, 32'h2000_00C4, 32'h8E);
    put_desc(32'h80, 1'b0, 32'hFF_FFFF, 32'h3000_0003, 32'h4000_0013, 32'h1);
    stall_rd = 1'b1; stall_mv = 1'b1;
    kick(1'b1, 32'h4C);
    wait_end();
    stall_rd = 1'b0; stall_mv = 1'b0;
    chk("R2 request count", 32'(req_n), 14);
    for (int i = 0; i < 7; i++) begin
      chk("R2 R5 first descriptor address", req_log[i], 32'h40 + 32'(4*i));
      chk("R2 R5 masked link address", req_log[7+i], 32'h80 + 32'(4*i));
    end
    chk("R6 two transfers", 32'(iss_n), 2);
    chk("R3 words before first issue", 32'(iss_w[0]), 7);
    chk("R3 words before second issue", 32'(iss_w[1]), 14);
    chk("R4 dir l2r", 32'(iss_dir[0]), 1);
    chk("R4 count l2r", 32'(iss_cnt[0]), 32'h100);
    chk("R4 src l2r", iss_src[0], 32'h1000_0004);
    chk("R4 dst l2r", iss_dst[0], 32'h2000_00C4);
    chk("R4 dir r2l", 32'(iss_dir[1]), 0);
    chk("R4 R7 max count", 32'(iss_cnt[1]), 32'hFF_FFFF);
    chk("R4 src r2l", iss_src[1], 32'h4000_0013);
    chk("R4 dst r2l", iss_dst[1], 32'h3000_0003);
    chk("R6 done pulse", 32'(d1), 1);
    chk("R6 done one cycle", 32'(d2), 0);
    chk("R6 no error", 32'(le), 0);
  endtask

  task automatic t_zero_count_mid();
    reset_logs();
    put_desc(32'h40, 1'b1, 32'h8, 32'h10, 32'h20, 32'h80);
    put_desc(32'h80, 1'b1, 32'h0, 32'h10, 32'h20, 32'h1);
    kick(1'b1, 32'h40);
    wait_end();
    chk("R7 earlier transfer kept", 32'(iss_n), 1);
    chk("R7 lerr on zero count", 32'(le), 1);
    chk("R7 no done", 32'(d1), 0);
    chk("R7 no done later", 32'(d2), 0);
  endtask

  task automatic t_big_count();
    reset_logs();
    put_desc(32'h40, 1'b0, 32'h0100_0000, 32'h10, 32'h20, 32'h1);
    kick(1'b1, 32'h40);
    wait_end();
    chk("R7 oversize not issued", 32'(iss_n), 0);
    chk("R7 lerr oversize", 32'(le), 1);
    chk("R3 words read", 32'(req_n), 7);
  endtask

  task automatic t_lane_mismatch();
    reset_logs();
    put_desc(32'h40, 1'b1, 32'h8, 32'h101, 32'h202, 32'h1);
    kick(1'b1, 32'h40);
    wait_end();
    chk("R8 mismatch not issued", 32'(iss_n), 0);
    chk("R8 lerr", 32'(le), 1);
    chk("R11 lerr sticky", 32'(lerr), 1);
  endtask

  task automatic t_direct();
    reset_logs();
    dir_l2r = 1'b0; dir_count = 32'h20; dir_laddr = 32'h500; dir_raddr = 32'h908;
    kick(1'b0, 32'h0);
    wait_end();
    chk("R11 lerr cleared by start", 32'(le), 0);
    chk("R9 no reads", 32'(req_n), 0);
    chk("R9 one transfer", 32'(iss_n), 1);
    chk("R9 src", iss_src[0], 32'h908);
    chk("R9 dst", iss_dst[0], 32'h500);
    chk("R9 count", 32'(iss_cnt[0]), 32'h20);
    chk("R9 done", 32'(d1), 1);
  endtask

  task automatic t_start_busy();
    reset_logs();
    put_desc(32'h40, 1'b1, 32'h44, 32'h700, 32'h800, 32'h1);
    dir_l2r = 1'b0; dir_count = 32'h0; dir_laddr = 32'h1; dir_raddr = 32'h2;
    kick(1'b1, 32'h40);
    repeat (3) @(negedge clk);
    start = 1'b1; chain_mode = 1'b0;
    @(negedge clk);
    start = 1'b0;
    wait_end();
    chk("R11 reads unaffected", 32'(req_n), 7);
    chk("R11 one transfer", 32'(iss_n), 1);
    chk("R11 chain fields kept", iss_src[0], 32'h700);
    chk("R11 no error", 32'(le), 0);
    chk("R11 done", 32'(d1), 1);
  endtask

  task automatic t_direct_bad();
    reset_logs();
    dir_l2r = 1'b1; dir_count = 32'h0; dir_laddr = 32'h10; dir_raddr = 32'h20;
    kick(1'b0, 32'h0);
    wait_end();
    chk("R9 R7 direct rejected", 32'(iss_n), 0);
    chk("R9 R7 direct lerr", 32'(le), 1);
    chk("R9 R7 direct no done", 32'(d1), 0);
  endtask

  initial begin
    reset_logs();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_chain_two();
    t_zero_count_mid();
    t_big_count();
    t_lane_mismatch();
    t_direct();
    t_start_busy();
    t_direct_bad();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule